// File: doc/BRIEF.md
# Two-Port Token Flag Bank

This block keeps eight one-bit ownership tokens that a left and a right processor share. The tokens live in an address space of their own, apart from any data memory. Each side reaches the bank through its own select, a 3-bit flag number, a write strobe and a data bit. A side writes 0 to ask for a token and writes 1 to give it back. It then reads the flag to learn whether it holds the token. The bank never stalls either side. Every write completes in one clock, and software learns the outcome by reading back.

Each flag is an independent state machine with five states:
- `SEM_FREE`: nobody holds the token.
- `SEM_LEFT`: the left side holds it.
- `SEM_RIGHT`: the right side holds it.
- `SEM_LEFT_RWAIT`: the left side holds it and the right side is waiting.
- `SEM_RIGHT_LWAIT`: the right side holds it and the left side is waiting.

The transitions are:
- **grant**: FREE to LEFT or RIGHT, when one side asks.
- **tie**: FREE to LEFT_RWAIT, when both sides ask in the same cycle. The left side wins.
- **queue**: LEFT to LEFT_RWAIT, or RIGHT to RIGHT_LWAIT, when the other side asks for a held token.
- **release**: LEFT or RIGHT back to FREE.
- **release-and-take**: LEFT to RIGHT, or RIGHT to LEFT, when the holder gives back in the same cycle that the other side asks.
- **handover**: a waiting state passes the token to the waiting side when the holder gives it back.
- **withdraw**: a waiting state drops the waiting side when that side writes 1.
- **both-release**: a waiting state goes to FREE when the holder and the waiting side both write 1 in the same cycle.

The bank drives no hardware resource. What a token means is up to software.

Top module: `sem_token_bank`

## Requirements
- R1: After reset every flag is free, no side is waiting, and a read of any flag number returns 1 on both sides.
- R2: A write with data 0 to a free flag gives that side the token at the next clock edge. From then on that side reads 0 and the other side reads 1.
- R3: When both sides write 0 to the same free flag in one cycle, the left side gets the token and the right side is recorded as waiting. The right side reads 1.
- R4: A write of 0 to a flag that the other side holds records the writer as waiting. When the holder writes 1, the token passes to the waiting side at that edge, so the waiting side reads 0 on its next access.
- R5: A write of 1 from a side that neither holds nor waits on the flag leaves the flag unchanged.
- R6: A waiting side that writes 1 withdraws its wait. A later release by the holder leaves the flag free.
- R7: Flag numbers 0 to 7 select independent flags. An access to one flag never changes another.
- R8: A side does nothing while its select `*_sem_n` is high. A selected access with the write strobe low changes nothing. A deselected side reads 1.
- R9: `*_standby` is 1 exactly when that side's RAM enable `*_ce_n` and its select `*_sem_n` are both high.
- R10: A holder that writes 0 again to its own flag keeps the token.
- R11: No flag ever reads 0 to both sides at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_ce_n | input | 1 | Left RAM enable, active low, used only for standby |
| l_sem_n | input | 1 | Left flag-bank select, active low |
| l_we | input | 1 | Left write strobe, active high |
| l_idx | input | 3 | Left flag number |
| l_wdata | input | 1 | Left write data: 0 asks for the token, 1 gives it back |
| l_rdata | output | 1 | Left read: 0 means the left side holds the selected flag |
| l_standby | output | 1 | Left side idle |
| r_ce_n | input | 1 | Right RAM enable, active low, used only for standby |
| r_sem_n | input | 1 | Right flag-bank select, active low |
| r_we | input | 1 | Right write strobe, active high |
| r_idx | input | 3 | Right flag number |
| r_wdata | input | 1 | Right write data: 0 asks for the token, 1 gives it back |
| r_rdata | output | 1 | Right read: 0 means the right side holds the selected flag |
| r_standby | output | 1 | Right side idle |

## Verification
A flag in the wrong state shows at the read ports on the first access after the edge that corrupted it. The read is combinational from the state register, so this is one clock after the offending write. A lost waiting record is hidden until the holder releases. It then shows as the waiting side reading 1 instead of 0 on the next read. A broken tie rule shows as the right side reading 0 after a simultaneous request. The bench therefore reads both sides right after every write and again right after each release.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

    typedef enum logic [2:0] {
        SEM_FREE        = 3'd0,
        SEM_LEFT        = 3'd1,
        SEM_RIGHT       = 3'd2,
        SEM_LEFT_RWAIT  = 3'd3,
        SEM_RIGHT_LWAIT = 3'd4
    } sem_state_e;

endpackage

// File: rtl/sem_port_decode.sv
// Turns one side's access into one-hot ask and give-back strobes per flag.
module sem_port_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic                 sem_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wdata,
    output logic [NUM_FLAGS-1:0] req,
    output logic [NUM_FLAGS-1:0] rel
);

    logic wr_active;
    assign wr_active = !sem_n && we;

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_dec
        logic hit;
        assign hit    = wr_active && (idx == IDX_W'(k));
        assign req[k] = hit && !wdata;
        assign rel[k] = hit &&  wdata;
    end

endmodule

// File: rtl/sem_flag_fsm.sv
// One token flag: who holds it and who waits for it.
module sem_flag_fsm
    import sem_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_own,
    output logic r_own,
    output logic l_pend,
    output logic r_pend
);

    sem_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEM_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (l_req && r_req) state_d = SEM_LEFT_RWAIT;
                else if (l_req)     state_d = SEM_LEFT;
                else if (r_req)     state_d = SEM_RIGHT;
            end
            SEM_LEFT: begin
                if (l_rel)      state_d = r_req ? SEM_RIGHT : SEM_FREE;
                else if (r_req) state_d = SEM_LEFT_RWAIT;
            end
            SEM_RIGHT: begin
                if (r_rel)      state_d = l_req ? SEM_LEFT : SEM_FREE;
                else if (l_req) state_d = SEM_RIGHT_LWAIT;
            end
            SEM_LEFT_RWAIT: begin
                if (l_rel && r_rel) state_d = SEM_FREE;
                else if (l_rel)     state_d = SEM_RIGHT;
                else if (r_rel)     state_d = SEM_LEFT;
            end
            SEM_RIGHT_LWAIT: begin
                if (l_rel && r_rel) state_d = SEM_FREE;
                else if (r_rel)     state_d = SEM_LEFT;
                else if (l_rel)     state_d = SEM_RIGHT;
            end
            default: state_d = SEM_FREE;
        endcase
    end

    always_comb begin
        l_own  = 1'b0;
        r_own  = 1'b0;
        l_pend = 1'b0;
        r_pend = 1'b0;
        unique case (state_q)
            SEM_FREE:        ;
            SEM_LEFT:        l_own = 1'b1;
            SEM_RIGHT:       r_own = 1'b1;
            SEM_LEFT_RWAIT:  begin l_own = 1'b1; r_pend = 1'b1; end
            SEM_RIGHT_LWAIT: begin r_own = 1'b1; l_pend = 1'b1; end
            default:         ;
        endcase
    end

endmodule

// File: rtl/sem_token_bank.sv
// Two-port bank of token flags with tie-breaking and queued handover.
module sem_token_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_ce_n,
    input  logic             l_sem_n,
    input  logic             l_we,
    input  logic [IDX_W-1:0] l_idx,
    input  logic             l_wdata,
    output logic             l_rdata,
    output logic             l_standby,
    input  logic             r_ce_n,
    input  logic             r_sem_n,
    input  logic             r_we,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_wdata,
    output logic             r_rdata,
    output logic             r_standby
);

    logic [NUM_FLAGS-1:0] l_req_v, l_rel_v, r_req_v, r_rel_v;
    logic [NUM_FLAGS-1:0] l_own_v, r_own_v, l_pend_v, r_pend_v;

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_l (
        .sem_n (l_sem_n),
        .we    (l_we),
        .idx   (l_idx),
        .wdata (l_wdata),
        .req   (l_req_v),
        .rel   (l_rel_v)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_r (
        .sem_n (r_sem_n),
        .we    (r_we),
        .idx   (r_idx),
        .wdata (r_wdata),
        .req   (r_req_v),
        .rel   (r_rel_v)
    );

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        sem_flag_fsm u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .l_req  (l_req_v[k]),
            .l_rel  (l_rel_v[k]),
            .r_req  (r_req_v[k]),
            .r_rel  (r_rel_v[k]),
            .l_own  (l_own_v[k]),
            .r_own  (r_own_v[k]),
            .l_pend (l_pend_v[k]),
            .r_pend (r_pend_v[k])
        );
    end

    // Reads come straight from the flag state: 0 tells the caller it holds the token.
    always_comb begin
        l_rdata = l_sem_n ? 1'b1 : !l_own_v[l_idx];
        r_rdata = r_sem_n ? 1'b1 : !r_own_v[r_idx];
    end

    assign l_standby = l_ce_n && l_sem_n;
    assign r_standby = r_ce_n && r_sem_n;

endmodule

// File: rtl/sem_token_bank_chk.sv
module sem_token_bank_chk #(
    parameter int NUM_FLAGS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_sem_n,
    input logic                 r_sem_n,
    input logic [NUM_FLAGS-1:0] l_req,
    input logic [NUM_FLAGS-1:0] l_rel,
    input logic [NUM_FLAGS-1:0] r_req,
    input logic [NUM_FLAGS-1:0] r_rel,
    input logic [NUM_FLAGS-1:0] l_own,
    input logic [NUM_FLAGS-1:0] r_own,
    input logic [NUM_FLAGS-1:0] l_pend,
    input logic [NUM_FLAGS-1:0] r_pend
);

    // R8: with both sides deselected nothing moves
    a_r8_quiet_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sem_n && r_sem_n) |=> ($stable(l_own) && $stable(r_own)
                                  && $stable(l_pend) && $stable(r_pend)));

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_chk
        // R11: never two holders
        a_r11_one_holder: assert property (@(posedge clk) disable iff (!rst_n)
            !(l_own[k] && r_own[k]));

        // R3: tie on a free flag goes left, right waits
        a_r3_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (l_req[k] && r_req[k] && !l_own[k] && !r_own[k])
            |=> (l_own[k] && r_pend[k]));

        // R2: a lone ask on a free flag is granted
        a_r2_grant_left: assert property (@(posedge clk) disable iff (!rst_n)
            (l_req[k] && !r_req[k] && !l_own[k] && !r_own[k]) |=> l_own[k]);

        // R4: release hands the token to the waiting side
        a_r4_handover: assert property (@(posedge clk) disable iff (!rst_n)
            (l_own[k] && r_pend[k] && l_rel[k] && !r_rel[k]) |=> r_own[k]);

        // R10: a holder keeps the token until it releases
        a_r10_left_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (l_own[k] && !l_rel[k]) |=> l_own[k]);
    end

endmodule

bind sem_token_bank sem_token_bank_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_sem_n (l_sem_n),
    .r_sem_n (r_sem_n),
    .l_req   (l_req_v),
    .l_rel   (l_rel_v),
    .r_req   (r_req_v),
    .r_rel   (r_rel_v),
    .l_own   (l_own_v),
    .r_own   (r_own_v),
    .l_pend  (l_pend_v),
    .r_pend  (r_pend_v)
);

// File: tb/sem_token_bank_bench.sv
module sem_token_bank_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_ce_n = 1'b1, l_sem_n = 1'b1, l_we = 1'b0, l_wdata = 1'b1;
    logic       r_ce_n = 1'b1, r_sem_n = 1'b1, r_we = 1'b0, r_wdata = 1'b1;
    logic [2:0] l_idx = '0, r_idx = '0;
    logic       l_rdata, r_rdata, l_standby, r_standby;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sem_token_bank u_sem_token_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .l_ce_n    (l_ce_n),
        .l_sem_n   (l_sem_n),
        .l_we      (l_we),
        .l_idx     (l_idx),
        .l_wdata   (l_wdata),
        .l_rdata   (l_rdata),
        .l_standby (l_standby),
        .r_ce_n    (r_ce_n),
        .r_sem_n   (r_sem_n),
        .r_we      (r_we),
        .r_idx     (r_idx),
        .r_wdata   (r_wdata),
        .r_rdata   (r_rdata),
        .r_standby (r_standby)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_sem_n = 1'b1; l_we = 1'b0; l_wdata = 1'b1;
        r_sem_n = 1'b1; r_we = 1'b0; r_wdata = 1'b1;
    endtask

    // side 0 = left, 1 = right
    task automatic wr(input bit side, input logic [2:0] idx, input logic d);
        @(negedge clk);
        if (side) begin r_sem_n = 1'b0; r_we = 1'b1; r_idx = idx; r_wdata = d; end
        else      begin l_sem_n = 1'b0; l_we = 1'b1; l_idx = idx; l_wdata = d; end
        @(negedge clk);
        idle();
    endtask

    task automatic wr_both(input logic [2:0] idx, input logic ld, input logic rd);
        @(negedge clk);
        l_sem_n = 1'b0; l_we = 1'b1; l_idx = idx; l_wdata = ld;
        r_sem_n = 1'b0; r_we = 1'b1; r_idx = idx; r_wdata = rd;
        @(negedge clk);
        idle();
    endtask

    task automatic peek(input logic [2:0] idx, output logic lv, output logic rv);
        @(negedge clk);
        l_sem_n = 1'b0; l_we = 1'b0; l_idx = idx;
        r_sem_n = 1'b0; r_we = 1'b0; r_idx = idx;
        #1;
        lv = l_rdata;
        rv = r_rdata;
        idle();
    endtask

    task automatic t_reset();
        logic lv, rv;
        for (int i = 0; i < 8; i++) begin
            peek(3'(i), lv, rv);
            chk("R1 left reads free after reset", lv, 1'b1);
            chk("R1 right reads free after reset", rv, 1'b1);
        end
        @(negedge clk); #1;
        chk("R9 left standby when both enables high", l_standby, 1'b1);
        chk("R9 right standby when both enables high", r_standby, 1'b1);
        l_ce_n = 1'b0; #1;
        chk("R9 left not standby with RAM enable low", l_standby, 1'b0);
        l_ce_n = 1'b1; r_sem_n = 1'b0; #1;
        chk("R9 right not standby with select low", r_standby, 1'b0);
        r_sem_n = 1'b1;
    endtask

    task automatic t_grant();
        logic lv, rv;
        wr(0, 3'd2, 1'b0);
        peek(3'd2, lv, rv);
        chk("R2 left granted", lv, 1'b0);
        chk("R2 right sees left token", rv, 1'b1);
        wr(1, 3'd5, 1'b0);
        peek(3'd5, lv, rv);
        chk("R2 right granted", rv, 1'b0);
        chk("R2 left sees right token", lv, 1'b1);
        peek(3'd2, lv, rv);
        chk("R7 flag 2 unaffected by flag 5", lv, 1'b0);
        wr(0, 3'd2, 1'b1);
        wr(1, 3'd5, 1'b1);
        peek(3'd2, lv, rv);
        chk("R2 flag 2 free after release", lv & rv, 1'b1);
        peek(3'd5, lv, rv);
        chk("R2 flag 5 free after release", lv & rv, 1'b1);
    endtask

    task automatic t_tie();
        logic lv, rv;
        wr_both(3'd3, 1'b0, 1'b0);
        peek(3'd3, lv, rv);
        chk("R3 left wins tie", lv, 1'b0);
        chk("R11 right not holder after tie", rv, 1'b1);
        wr(0, 3'd3, 1'b1);
        peek(3'd3, lv, rv);
        chk("R4 right waiting after tie takes token", rv, 1'b0);
        chk("R4 left lost token after release", lv, 1'b1);
        wr(1, 3'd3, 1'b1);
        peek(3'd3, lv, rv);
        chk("R4 flag 3 free at end", lv & rv, 1'b1);
    endtask

    task automatic t_queue();
        logic lv, rv;
        wr(1, 3'd1, 1'b0);
        wr(0, 3'd1, 1'b0);
        peek(3'd1, lv, rv);
        chk("R4 left asking on held flag waits", lv, 1'b1);
        chk("R4 right still holder", rv, 1'b0);
        wr(1, 3'd1, 1'b1);
        peek(3'd1, lv, rv);
        chk("R4 handover to left", lv, 1'b0);
        chk("R4 right released", rv, 1'b1);
        wr(0, 3'd1, 1'b1);
    endtask

    task automatic t_ignore();
        logic lv, rv;
        wr(0, 3'd6, 1'b0);
        wr(1, 3'd6, 1'b1);
        peek(3'd6, lv, rv);
        chk("R5 stray release ignored", lv, 1'b0);
        @(negedge clk);
        r_sem_n = 1'b1; r_we = 1'b1; r_idx = 3'd6; r_wdata = 1'b0;
        l_sem_n = 1'b1; l_idx = 3'd6; #1;
        chk("R8 deselected left reads 1", l_rdata, 1'b1);
        @(negedge clk);
        r_sem_n = 1'b0; r_we = 1'b0; r_wdata = 1'b0;
        @(negedge clk);
        idle();
        wr(0, 3'd6, 1'b1);
        peek(3'd6, lv, rv);
        chk("R8 deselected or read-only right access left no wait", rv, 1'b1);
        chk("R8 flag 6 free", lv, 1'b1);
    endtask

    task automatic t_withdraw();
        logic lv, rv;
        wr(0, 3'd4, 1'b0);
        wr(1, 3'd4, 1'b0);
        wr(1, 3'd4, 1'b1);
        peek(3'd4, lv, rv);
        chk("R6 left keeps token after withdraw", lv, 1'b0);
        wr(0, 3'd4, 1'b1);
        peek(3'd4, lv, rv);
        chk("R6 right gets nothing after withdraw", rv, 1'b1);
        chk("R6 flag free after withdraw", lv, 1'b1);
    endtask

    task automatic t_reown();
        logic lv, rv;
        wr(0, 3'd0, 1'b0);
        wr(0, 3'd0, 1'b0);
        peek(3'd0, lv, rv);
        chk("R10 repeat ask keeps token", lv, 1'b0);
        chk("R11 right not holder", rv, 1'b1);
        wr(0, 3'd0, 1'b1);
        peek(3'd0, lv, rv);
        chk("R10 single release frees", lv & rv, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_grant();
        t_tie();
        t_queue();
        t_ignore();
        t_withdraw();
        t_reown();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule